// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port with a zero-wait-state APB register interface. Each pin has a direction bit and an output data bit. Reads return either the value the port drives or the synchronized pad level. The pad drivers see two vectors: an output-enable and an output value.

The data register has no single address. Any word offset below 0x400 reaches it, and address bits [9:2] form a bit mask. A write changes only the pins whose mask bit is 1. A read returns zero for every pin whose mask bit is 0. Software can therefore set or clear one pin with a single write, with no read-modify-write and no lock. The direction register sits at 0x400. All other offsets read as zero and ignore writes.

A two-state access tracker follows the bus phases. ST_IDLE moves to ST_ACCESS on a setup phase (select high, enable low). ST_ACCESS returns to ST_IDLE when the access phase completes, or stays in ST_ACCESS when a fresh setup phase arrives instead. A register is updated only by an access phase seen in ST_ACCESS.

Top module: `gpio_mask_port`

## Requirements
- R1: Reset clears the direction and data registers: pad_oe and pad_out are 0, and a read of offset 0x400 returns 0.
- R2: A write to offset 0x400 loads the direction register from pwdata[7:0]. pad_oe equals it, with bit n = 1 making pin n an output. A read of 0x400 returns it.
- R3: A write to an offset below 0x400 uses paddr[9:2] as a mask. Data bit n is updated from pwdata[n] only when paddr[n+2] is 1; for example, offset 0x20 reaches only pin 3.
- R4: A data write leaves the stored value of any pin whose direction bit is 0 unchanged. pad_out[n] is 0 while pin n is an input. A value written while a pin is an input does not appear after the pin is made an output; it must be written again.
- R5: A read of an offset below 0x400 returns 0 in bit n when paddr[n+2] is 0. Otherwise it returns the driven value for an output pin and the synchronized pad level for an input pin.
- R6: pad_in passes through two flip-flops. A level change is not seen by a read whose setup phase starts in the same cycle, and it is seen by a read whose setup phase starts one cycle later.
- R7: prdata[31:8] reads 0, pready is 1 and pslverr is 0 on every access.
- R8: Offsets at or above 0x404 (for example 0x404 and 0x800) read as 0, and writes to them change no register.
- R9: An access phase (psel and penable high) that was not preceded by a setup phase changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write, 1 = write |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | Ready, always 1 |
| pslverr | output | 1 | Error, always 0 |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven value |

## Verification
The data window is exercised with a full mask (0x3FC), a one-pin mask (0x20 and 0x04), two-pin and nibble masks, and writes with data bits set outside the mask. These separate a correct mask decode from one that ignores or misplaces the address bits. Mixed directions with an alternating pad pattern show whether each read bit comes from the driven value or from the pad. A write made while pins are inputs, followed by a switch to output, shows whether input pins are really protected. Reads started in the cycle the pad changes, and one cycle later, pin down the synchronizer depth. Writes to out-of-map offsets and a bare access phase must leave the direction and data registers as they were.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    // Bus phase tracker states
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } apb_state_e;

endpackage

// File: rtl/gpio_mask_apb_fsm.sv
module gpio_mask_apb_fsm
    import gpio_mask_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_commit,
    output logic rd_active
);

    apb_state_e st_q;
    apb_state_e st_d;

    logic setup_phase;
    logic access_phase;

    assign setup_phase  = psel && !penable;
    assign access_phase = psel && penable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (setup_phase) st_d = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (setup_phase) st_d = ST_ACCESS;
                else             st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_commit = 1'b0;
        rd_active = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                wr_commit = 1'b0;
                rd_active = 1'b0;
            end
            ST_ACCESS: begin
                wr_commit = access_phase && pwrite;
                rd_active = access_phase && !pwrite;
            end
            default: begin
                wr_commit = 1'b0;
                rd_active = 1'b0;
            end
        endcase
    end

    // R9: the access state is only entered from a setup phase
    a_r9_access_after_setup: assert property (
        @(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACCESS) |-> $past(psel && !penable)
    );

endmodule

// File: rtl/gpio_mask_sync.sv
module gpio_mask_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

    if (STAGES == 2) begin : g_chk
        logic [1:0] warm_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              warm_q <= 2'd0;
            else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
        end

        // R6: output is the pad level sampled two edges earlier
        a_r6_two_flop_delay: assert property (
            @(posedge clk) disable iff (!rst_n)
            (warm_q == 2'd2) |-> (dout == $past(din, 2))
        );
    end

endmodule

// File: rtl/gpio_mask_regs.sv
module gpio_mask_regs #(
    parameter int          NPINS    = 8,
    parameter int          AW       = 12,
    parameter int          DW       = 32,
    parameter int          MASK_LSB = 2,
    parameter logic [11:0] DIR_ADDR = 12'h400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_commit,
    input  logic             rd_active,
    input  logic [AW-1:0]    paddr,
    input  logic [DW-1:0]    pwdata,
    input  logic [NPINS-1:0] pin_sync,
    output logic [DW-1:0]    prdata,
    output logic [NPINS-1:0] dir_o,
    output logic [NPINS-1:0] drv_o
);

    localparam int WIN_LSB = MASK_LSB + NPINS;

    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] mask;
    logic [NPINS-1:0] rd_value;
    logic             in_window;
    logic             is_dir;
    logic             wr_data;
    logic             wr_dir;
    logic [NPINS-1:0] wr_mask;
    logic             unused_bits;

    assign in_window = (paddr[AW-1:WIN_LSB] == '0);
    assign is_dir    = (paddr[AW-1:MASK_LSB] == DIR_ADDR[AW-1:MASK_LSB]);
    assign mask      = paddr[WIN_LSB-1:MASK_LSB];
    assign wr_data   = wr_commit && in_window;
    assign wr_dir    = wr_commit && is_dir;
    assign wr_mask   = mask & dir_q;

    assign unused_bits = &{1'b0, paddr[MASK_LSB-1:0], pwdata[DW-1:NPINS]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= pwdata[NPINS-1:0];
    end

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    out_q[n] <= 1'b0;
            else if (wr_data && wr_mask[n]) out_q[n] <= pwdata[n];
        end
    end

    always_comb begin
        if (in_window)   rd_value = mask & ((dir_q & out_q) | (~dir_q & pin_sync));
        else if (is_dir) rd_value = dir_q;
        else             rd_value = '0;
    end

    assign prdata = rd_active ? {{(DW-NPINS){1'b0}}, rd_value} : '0;
    assign dir_o  = dir_q;
    assign drv_o  = out_q & dir_q;

    // R2: direction write loads the written byte
    a_r2_dir_load: assert property (
        @(posedge clk) disable iff (!rst_n)
        wr_dir |=> (dir_q == $past(pwdata[NPINS-1:0]))
    );

    // R3: selected output pins take the written value
    a_r3_written_value: assert property (
        @(posedge clk) disable iff (!rst_n)
        wr_data |=> (((out_q ^ $past(pwdata[NPINS-1:0])) & $past(wr_mask)) == '0)
    );

    // R3: pins outside the address mask keep their value
    a_r3_unmasked_hold: assert property (
        @(posedge clk) disable iff (!rst_n)
        wr_data |=> (((out_q ^ $past(out_q)) & ~$past(mask)) == '0)
    );

    // R4: input pins keep their stored value on a data write
    a_r4_input_pin_hold: assert property (
        @(posedge clk) disable iff (!rst_n)
        wr_data |=> (((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0)
    );

    // R5: unselected bits read as zero
    a_r5_unmasked_read_zero: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rd_active && in_window) |-> ((prdata[NPINS-1:0] & ~mask) == '0)
    );

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
    parameter int          NPINS    = 8,
    parameter int          AW       = 12,
    parameter int          DW       = 32,
    parameter int          SYNC_FF  = 2,
    parameter logic [11:0] DIR_ADDR = 12'h400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [AW-1:0]    paddr,
    input  logic [DW-1:0]    pwdata,
    output logic [DW-1:0]    prdata,
    output logic             pready,
    output logic             pslverr,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out
);

    localparam int MASK_LSB = 2;

    logic             wr_commit;
    logic             rd_active;
    logic [NPINS-1:0] pin_sync;

    gpio_mask_apb_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .wr_commit (wr_commit),
        .rd_active (rd_active)
    );

    gpio_mask_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_FF)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pin_sync)
    );

    gpio_mask_regs #(
        .NPINS    (NPINS),
        .AW       (AW),
        .DW       (DW),
        .MASK_LSB (MASK_LSB),
        .DIR_ADDR (DIR_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_commit (wr_commit),
        .rd_active (rd_active),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .pin_sync  (pin_sync),
        .prdata    (prdata),
        .dir_o     (pad_oe),
        .drv_o     (pad_out)
    );

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        psel;
    logic        penable;
    logic        pwrite;
    logic [11:0] paddr;
    logic [31:0] pwdata;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic [7:0]  pad_in;
    logic [7:0]  pad_oe;
    logic [7:0]  pad_out;

    gpio_mask_port u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .pready  (pready),
        .pslverr (pslverr),
        .pad_in  (pad_in),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    int          n_checks = 0;
    int          n_fail   = 0;
    logic [31:0] exp_q [$];
    string       req_q [$];
    logic        mon_arm  = 1'b0;
    logic [7:0]  dir_m    = 8'h00;
    logic [7:0]  out_m    = 8'h00;

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [11:0] a);
        logic [7:0] m;
        m = a[9:2];
        if (a[11:10] == 2'b00)       return {24'h0, m & ((dir_m & out_m) | (~dir_m & pad_in))};
        else if (a[11:2] == 10'h100) return {24'h0, dir_m};
        else                         return 32'h0;
    endfunction

    // Monitor: compares each read access against the scoreboard queue
    always @(negedge clk) begin
        if (mon_arm) begin
            if (exp_q.size() == 0) begin
                chk("queue", 32'h1, 32'h0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string       r = req_q.pop_front();
                chk(r, prdata, e);
                chk("R7", {30'h0, pready, pslverr}, 32'h2);
            end
        end
    end

    task automatic apb_read(input logic [11:0] a, input logic [31:0] e, input string r,
                            input logic chg = 1'b0, input logic [7:0] newpad = 8'h00);
        @(posedge clk); #2;
        if (chg) pad_in = newpad;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        exp_q.push_back(e);
        req_q.push_back(r);
        @(posedge clk); #2;
        penable = 1'b1; mon_arm = 1'b1;
        @(posedge clk); #2;
        psel = 1'b0; penable = 1'b0; mon_arm = 1'b0;
    endtask

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        logic [7:0] m;
        @(posedge clk); #2;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(posedge clk); #2;
        penable = 1'b1;
        @(posedge clk); #2;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        m = a[9:2];
        if (a[11:2] == 10'h100)      dir_m = d[7:0];
        else if (a[11:10] == 2'b00)  out_m = (out_m & ~(m & dir_m)) | (d[7:0] & m & dir_m);
    endtask

    task automatic chk_pads(input string r);
        @(negedge clk);
        chk(r, {24'h0, pad_oe},  {24'h0, dir_m});
        chk(r, {24'h0, pad_out}, {24'h0, out_m & dir_m});
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        paddr = '0; pwdata = '0; pad_in = 8'h00;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state
        chk_pads("R1");
        apb_read(12'h400, 32'h0, "R1");
        apb_read(12'h3FC, 32'h0, "R1");

        // R4: write while all pins are inputs, then make them outputs
        apb_write(12'h3FC, 32'hFFFF_FFFF);
        apb_write(12'h400, 32'h0000_00FF);
        chk_pads("R4");
        chk("R4", {24'h0, pad_out}, 32'h0);
        apb_read(12'h400, 32'hFF, "R2");

        // R3: full, single-pin and two-pin masks
        apb_write(12'h3FC, 32'h0000_00A5);
        chk_pads("R3");
        apb_write(12'h020, 32'h0000_00FF);
        chk_pads("R3");
        chk("R3", {24'h0, pad_out}, 32'hAD);
        apb_write(12'h00C, 32'h0000_0000);
        chk_pads("R3");
        chk("R3", {24'h0, pad_out}, 32'hAC);

        // R5: masked reads of output pins
        apb_read(12'h020, 32'h08, "R5");
        apb_read(12'h004, 32'h00, "R5");
        apb_read(12'h3FC, 32'hAC, "R5");

        // R2 / R5: mixed direction, pad pattern on inputs
        apb_write(12'h400, 32'h0000_000F);
        chk_pads("R2");
        pad_in = 8'h5A;
        repeat (3) @(posedge clk);
        apb_read(12'h3FC, 32'h5C, "R5");
        apb_read(12'h3C0, model_rd(12'h3C0), "R5");
        apb_read(12'h03C, model_rd(12'h03C), "R5");

        // R4: write with upper pins as inputs, then turn them into outputs
        apb_write(12'h3FC, 32'h0000_00FF);
        chk_pads("R4");
        apb_write(12'h400, 32'h0000_00FF);
        chk_pads("R4");
        chk("R4", {24'h0, pad_out}, 32'hAF);

        // R6: synchronizer depth
        apb_write(12'h400, 32'h0000_0000);
        pad_in = 8'h00;
        repeat (3) @(posedge clk);
        apb_read(12'h3FC, 32'h00, "R6", 1'b1, 8'hFF);
        apb_read(12'h3FC, 32'hFF, "R6");

        // R8: out-of-map offsets
        apb_write(12'h404, 32'h0000_00FF);
        apb_write(12'h800, 32'h0000_00FF);
        chk_pads("R8");
        apb_read(12'h404, 32'h0, "R8");
        apb_read(12'h800, 32'h0, "R8");
        apb_read(12'h400, 32'h0, "R8");

        // R9: bare access phase without setup
        @(posedge clk); #2;
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = 12'h400; pwdata = 32'hFF;
        @(posedge clk); #2;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        chk_pads("R9");
        apb_read(12'h400, 32'h0, "R9");

        // R7: upper read bits zero with pads all high and all outputs set
        apb_write(12'h400, 32'h0000_00FF);
        apb_read(12'h3FC, {24'h0, out_m}, "R7");

        repeat (2) @(posedge clk);
        chk("queue", exp_q.size(), 32'h0);
        summary();
        $finish;
    end

endmodule